// File: doc/BRIEF.md
# Message-Signalled Interrupt Collector

This block sits next to a PCIe root port. It takes the memory writes that devices send as message-signalled interrupts and turns them into one level-sensitive interrupt line for the host processor. Software programs a 64-bit target address for the messages. It selects which of 32 vectors may be captured and which captured vectors may raise the line. It acknowledges captured vectors by writing ones to a status word.

Inbound memory writes arrive on a separate port. These writes have already been decoded from transaction packets. A write counts as a message only while at least one vector is enabled and its address falls in the 4 KiB window that starts at the programmed address. The write's data value names the vector. The register interface also holds a read-only link status word and two placeholder control words. These exist so that driver code that probes them keeps working; they have no function behind them.

Top module: `msi_irq_ctrl`

## Requirements
- R1: Register byte offsets are fixed: 0x820 target address low half, 0x824 target address high half, 0x828 vector enable, 0x82C vector mask, 0x830 vector status. Reads return the stored value, and any unlisted offset reads as zero.
- R2: Writing one half of the 64-bit target address leaves the other half unchanged.
- R3: An inbound message with data value N (0 to 31) sets status bit N on the next clock edge only if enable bit N is set. If enable bit N is clear, the status word is unchanged.
- R4: The interrupt output is high exactly while some status bit is set whose mask bit is clear. Masking does not alter status.
- R5: A write to the status offset clears each status bit written as one and keeps the bits written as zero.
- R6: When a status write leaves the status word at zero, the interrupt output is low.
- R7: An inbound message is captured only while the enable word is nonzero and its address A satisfies base <= A < base + 0x1000.
- R8: Offset 0x72C reads 0x00000010 (bit 4, link up). Offsets 0x710 and 0x80C read 0xDEADBEEF. Writes to these three offsets change nothing.
- R9: Reset clears the address, enable, mask and status words and holds the interrupt output low.
- R10: An inbound message with data value 32 or more changes no status bit.
- R11: When a capture of vector N and a status write clearing bit N land in the same cycle, bit N ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| msi_wr_en | input | 1 | Inbound memory write valid |
| msi_wr_addr | input | 64 | Inbound memory write address |
| msi_wr_data | input | 32 | Inbound memory write data (vector number) |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with its defaults: 32 vectors, a 64-bit target address and a 4 KiB window. These values place the target address above the 4 GiB line, so the test covers both address halves, the last word inside the window and the first address past it. With all 32 vectors present, bit 31 and the out-of-range data value 32 sit right next to each other. The bench also drives a capture and an acknowledge of the same vector in one cycle to check which one wins.

// File: rtl/msi_irq_pkg.sv
// Shared offsets and constants for the message-signalled interrupt collector.
// Assumes a 12-bit byte offset on the register interface.
package msi_irq_pkg;
    localparam int REG_AW = 12;
    localparam logic [REG_AW-1:0] OFS_TGT_LO    = 12'h820;
    localparam logic [REG_AW-1:0] OFS_TGT_HI    = 12'h824;
    localparam logic [REG_AW-1:0] OFS_VEC_EN    = 12'h828;
    localparam logic [REG_AW-1:0] OFS_VEC_MASK  = 12'h82C;
    localparam logic [REG_AW-1:0] OFS_VEC_STAT  = 12'h830;
    localparam logic [REG_AW-1:0] OFS_LINK_STAT = 12'h72C;
    localparam logic [REG_AW-1:0] OFS_PORT_CTL  = 12'h710;
    localparam logic [REG_AW-1:0] OFS_LANE_CTL  = 12'h80C;
    localparam logic [31:0] LINK_UP_WORD = 32'h0000_0010;
    localparam logic [31:0] FILLER_WORD  = 32'hDEAD_BEEF;
endpackage

// File: rtl/msi_tgt_addr.sv
// Holds the message target address as two separately written halves.
// Assumes ADDR_W is above 32; the high half takes the upper ADDR_W-32 bits.
module msi_tgt_addr #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [31:0]       wdata,
    output logic [ADDR_W-1:0] base
);
    localparam int HI_W = ADDR_W - 32;

    logic [31:0]     lo_q;
    logic [HI_W-1:0] hi_q;

    // Update each half only on its own write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo) lo_q <= wdata;
            if (wr_hi) hi_q <= wdata[HI_W-1:0];
        end
    end

    assign base = {hi_q, lo_q};
endmodule

// File: rtl/msi_window.sv
// Decides whether an inbound write falls in the armed message window.
// Assumes base + WINDOW_BYTES does not wrap past the top of the address space.
module msi_window #(
    parameter int ADDR_W       = 64,
    parameter int WINDOW_BYTES = 4096
) (
    input  logic              armed,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(WINDOW_BYTES);

    logic [ADDR_W-1:0] offset;

    // Offset from base, valid only when addr is not below base.
    always_comb begin
        offset = addr - base;
        hit    = armed && (addr >= base) && (offset < SPAN);
    end
endmodule

// File: rtl/msi_vec_bank.sv
// Per-vector enable, mask and status storage with the level interrupt.
// Assumes at most one capture per cycle; a capture beats a same-cycle clear.
module msi_vec_bank #(
    parameter int VEC_COUNT = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en_wr,
    input  logic                         mask_wr,
    input  logic                         clr_wr,
    input  logic [31:0]                  wdata,
    input  logic                         cap_valid,
    input  logic [$clog2(VEC_COUNT)-1:0] cap_idx,
    output logic [VEC_COUNT-1:0]         enable,
    output logic [VEC_COUNT-1:0]         mask,
    output logic [VEC_COUNT-1:0]         status,
    output logic                         irq
);
    logic [VEC_COUNT-1:0] en_q, mask_q, stat_q;

    // Enable and mask words follow their register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
        end else begin
            if (en_wr)   en_q   <= wdata[VEC_COUNT-1:0];
            if (mask_wr) mask_q <= wdata[VEC_COUNT-1:0];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < VEC_COUNT; gi++) begin : g_vec
            logic set_b, clr_b;
            assign set_b = cap_valid && (cap_idx == gi) && en_q[gi];
            assign clr_b = clr_wr && wdata[gi];
            // One status bit: set by capture, cleared by write-one, set wins.
            always_ff @(posedge clk) begin
                if (!rst_n)     stat_q[gi] <= 1'b0;
                else if (set_b) stat_q[gi] <= 1'b1;
                else if (clr_b) stat_q[gi] <= 1'b0;
            end
        end
    endgenerate

    assign enable = en_q;
    assign mask   = mask_q;
    assign status = stat_q;
    assign irq    = |(stat_q & ~mask_q);
endmodule

// File: rtl/msi_irq_ctrl.sv
// Top of the message-signalled interrupt collector: register decode, read
// multiplexer, window check and vector bank. Reads are combinational on
// reg_addr; writes take effect at the next clock edge.
module msi_irq_ctrl
    import msi_irq_pkg::*;
#(
    parameter int VEC_COUNT    = 32,
    parameter int ADDR_W       = 64,
    parameter int WINDOW_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              msi_wr_en,
    input  logic [63:0]       msi_wr_addr,
    input  logic [31:0]       msi_wr_data,
    output logic              irq
);
    localparam int IDX_W = $clog2(VEC_COUNT);
    localparam int HI_W  = ADDR_W - 32;

    logic [ADDR_W-1:0]    base_q;
    logic [VEC_COUNT-1:0] vec_enable, vec_mask, vec_status;
    logic                 win_hit, cap_valid;
    logic                 wr_lo, wr_hi, wr_en, wr_mask, wr_stat;

    // Write strobes per register offset.
    always_comb begin
        wr_lo   = reg_wr_en && (reg_addr == OFS_TGT_LO);
        wr_hi   = reg_wr_en && (reg_addr == OFS_TGT_HI);
        wr_en   = reg_wr_en && (reg_addr == OFS_VEC_EN);
        wr_mask = reg_wr_en && (reg_addr == OFS_VEC_MASK);
        wr_stat = reg_wr_en && (reg_addr == OFS_VEC_STAT);
    end

    msi_tgt_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wdata(reg_wdata), .base(base_q)
    );

    msi_window #(.ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW_BYTES)) u_win (
        .armed(|vec_enable), .base(base_q), .addr(msi_wr_addr[ADDR_W-1:0]),
        .hit(win_hit)
    );

    // A message is usable only inside the window and with an in-range vector.
    assign cap_valid = msi_wr_en && win_hit && (msi_wr_data < 32'(VEC_COUNT));

    msi_vec_bank #(.VEC_COUNT(VEC_COUNT)) u_bank (
        .clk(clk), .rst_n(rst_n), .en_wr(wr_en), .mask_wr(wr_mask),
        .clr_wr(wr_stat), .wdata(reg_wdata), .cap_valid(cap_valid),
        .cap_idx(msi_wr_data[IDX_W-1:0]), .enable(vec_enable),
        .mask(vec_mask), .status(vec_status), .irq(irq)
    );

    // Read multiplexer over all decoded offsets.
    always_comb begin
        unique case (reg_addr)
            OFS_TGT_LO:    reg_rdata = base_q[31:0];
            OFS_TGT_HI:    reg_rdata = 32'(base_q[ADDR_W-1 -: HI_W]);
            OFS_VEC_EN:    reg_rdata = 32'(vec_enable);
            OFS_VEC_MASK:  reg_rdata = 32'(vec_mask);
            OFS_VEC_STAT:  reg_rdata = 32'(vec_status);
            OFS_LINK_STAT: reg_rdata = LINK_UP_WORD;
            OFS_PORT_CTL:  reg_rdata = FILLER_WORD;
            OFS_LANE_CTL:  reg_rdata = FILLER_WORD;
            default:       reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/msi_irq_ctrl_chk.sv
// Property checker for msi_irq_ctrl, attached by bind below. Assumes the
// default of 32 vectors so a 5-bit data slice indexes the status word.
module msi_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [11:0] reg_addr,
    input logic [31:0] reg_wdata,
    input logic        msi_wr_en,
    input logic [31:0] msi_wr_data,
    input logic        win_hit,
    input logic [31:0] vec_enable,
    input logic [31:0] vec_status,
    input logic [63:0] base_q,
    input logic        irq
);
    logic stat_wr, in_range;
    assign stat_wr  = reg_wr_en && (reg_addr == 12'h830);
    assign in_range = msi_wr_data < 32'd32;

    // R3: an enabled in-window message sets its status bit.
    p_capture_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_wr_en && win_hit && in_range && vec_enable[msi_wr_data[4:0]])
        |=> vec_status[$past(msi_wr_data[4:0])]);

    // R3: a disabled vector's status bit does not change without a write.
    p_disabled_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_wr_en && in_range && !vec_enable[msi_wr_data[4:0]] && !stat_wr)
        |=> vec_status[$past(msi_wr_data[4:0])] == $past(vec_status[msi_wr_data[4:0]]));

    // R5: a status write with no message clears exactly the ones written.
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !msi_wr_en)
        |=> vec_status == ($past(vec_status) & ~$past(reg_wdata)));

    // R6: an empty status word keeps the line low.
    p_irq_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_status == '0) |-> !irq);

    // R7: with every vector disabled, messages leave status alone.
    p_window_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_enable == '0 && msi_wr_en && !stat_wr) |=> $stable(vec_status));

    // R2: a low-half write keeps the high half.
    p_half_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 12'h820) |=> $stable(base_q[63:32]));
endmodule

bind msi_irq_ctrl msi_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .msi_wr_en(msi_wr_en), .msi_wr_data(msi_wr_data),
    .win_hit(win_hit), .vec_enable(vec_enable), .vec_status(vec_status),
    .base_q(base_q), .irq(irq)
);

// File: tb/msi_irq_ctrl_test.sv
// Directed bench for msi_irq_ctrl: one task per scenario.
module msi_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] BASE = 64'h0000_0001_8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msi_wr_en = 1'b0;
    logic [63:0] msi_wr_addr = '0;
    logic [31:0] msi_wr_data = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_wr_en(msi_wr_en),
        .msi_wr_addr(msi_wr_addr), .msi_wr_data(msi_wr_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic msi(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        msi_wr_en = 1'b1; msi_wr_addr = a; msi_wr_data = d;
        @(negedge clk);
        msi_wr_en = 1'b0;
    endtask

    task automatic t_reset_state();
        rd_check("R9 addr lo", 12'h820, 32'h0);
        rd_check("R9 addr hi", 12'h824, 32'h0);
        rd_check("R9 enable", 12'h828, 32'h0);
        rd_check("R9 mask", 12'h82C, 32'h0);
        rd_check("R9 status", 12'h830, 32'h0);
        check("R9 irq", 32'(irq), 32'h0);
        rd_check("R1 unmapped", 12'h834, 32'h0);
    endtask

    task automatic t_addr_halves();
        wr(12'h820, 32'h8000_0000);
        wr(12'h824, 32'h0000_0001);
        rd_check("R2 lo", 12'h820, 32'h8000_0000);
        rd_check("R2 hi", 12'h824, 32'h0000_0001);
        wr(12'h820, 32'h1234_5678);
        rd_check("R2 hi kept", 12'h824, 32'h0000_0001);
        wr(12'h820, BASE[31:0]);
        rd_check("R1 lo back", 12'h820, BASE[31:0]);
    endtask

    task automatic t_fixed_words();
        wr(12'h72C, 32'h0);
        wr(12'h710, 32'h0);
        wr(12'h80C, 32'h0);
        rd_check("R8 link", 12'h72C, 32'h0000_0010);
        rd_check("R8 port ctl", 12'h710, 32'hDEAD_BEEF);
        rd_check("R8 lane ctl", 12'h80C, 32'hDEAD_BEEF);
        rd_check("R8 others kept", 12'h820, BASE[31:0]);
    endtask

    task automatic t_window_closed();
        msi(BASE, 32'd3);
        rd_check("R7 closed", 12'h830, 32'h0);
        check("R7 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_capture();
        wr(12'h828, 32'h8000_00FF);
        rd_check("R1 enable", 12'h828, 32'h8000_00FF);
        msi(BASE, 32'd3);
        rd_check("R3 set", 12'h830, 32'h0000_0008);
        check("R4 irq up", 32'(irq), 32'h1);
        msi(BASE, 32'd9);
        rd_check("R3 disabled", 12'h830, 32'h0000_0008);
        msi(BASE + 64'hFFC, 32'd4);
        rd_check("R7 last word", 12'h830, 32'h0000_0018);
        msi(BASE + 64'h1000, 32'd5);
        rd_check("R7 past end", 12'h830, 32'h0000_0018);
        msi(BASE - 64'h4, 32'd5);
        rd_check("R7 below", 12'h830, 32'h0000_0018);
        msi(BASE, 32'd31);
        rd_check("R3 bit31", 12'h830, 32'h8000_0018);
        msi(BASE, 32'd32);
        rd_check("R10 data 32", 12'h830, 32'h8000_0018);
    endtask

    task automatic t_mask();
        wr(12'h82C, 32'h8000_0018);
        check("R4 masked", 32'(irq), 32'h0);
        rd_check("R4 status kept", 12'h830, 32'h8000_0018);
        wr(12'h82C, 32'h8000_0008);
        check("R4 unmasked", 32'(irq), 32'h1);
        wr(12'h82C, 32'h0);
    endtask

    task automatic t_clear();
        wr(12'h830, 32'h0000_0008);
        rd_check("R5 partial", 12'h830, 32'h8000_0010);
        check("R5 irq held", 32'(irq), 32'h1);
        wr(12'h830, 32'h8000_0010);
        rd_check("R5 all", 12'h830, 32'h0);
        check("R6 irq low", 32'(irq), 32'h0);
    endtask

    task automatic t_collision();
        msi(BASE, 32'd5);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 12'h830; reg_wdata = 32'h0000_0021;
        msi_wr_en = 1'b1; msi_wr_addr = BASE; msi_wr_data = 32'd5;
        @(negedge clk);
        reg_wr_en = 1'b0; msi_wr_en = 1'b0;
        rd_check("R11 capture wins", 12'h830, 32'h0000_0020);
        check("R11 irq", 32'(irq), 32'h1);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_check("R9 status cleared", 12'h830, 32'h0);
        rd_check("R9 enable cleared", 12'h828, 32'h0);
        rd_check("R9 hi cleared", 12'h824, 32'h0);
        check("R9 irq cleared", 32'(irq), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_addr_halves();
        t_fixed_words();
        t_window_closed();
        t_capture();
        t_mask();
        t_clear();
        t_collision();
        t_reset_again();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule